// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block generates the column addresses of one read or write burst inside a bank of a synchronous DRAM. A controller pulses a load strobe with a 9-bit starting column, a burst length code and an ordering select. From the next clock on, the block presents one column per clock until the programmed number of columns has gone out. It flags the final column of a finite burst on the same cycle as that column.

Two orderings are offered. In sequential order the low bits count upward and wrap inside the aligned block that the burst length defines. In interleaved order the low bits are the starting column XOR the beat index. A full-page length walks all 512 columns in sequential order and repeats until it is stopped. A stop strobe ends the burst at once. A new load on any cycle discards the burst in progress and starts again from the new column. Array access and data movement are handled elsewhere.

Top module: `burst_col_counter`

## Requirements
- R1: While reset is low and on the first cycle after it, `col_vld_o` and `last_o` are 0.
- R2: A load sampled at a clock edge makes `col_vld_o` 1 and `col_o` equal to the loaded start column from that edge on. Each further edge then advances the burst by exactly one column.
- R3: Length codes are 3'b000 = 1, 3'b001 = 2, 3'b010 = 4, 3'b011 = 8 and 3'b111 = full page. A finite burst shows exactly that many columns. `last_o` is 1 on the final one only, and `col_vld_o` is 0 on the cycle after it.
- R4: Sequential order (`order_i` = 0) gives beat k the column whose bits above log2(BL) equal the start's, and whose low log2(BL) bits are (start + k) mod BL.
- R5: Interleaved order (`order_i` = 1) gives beat k the column start XOR k, for k from 0 to BL-1.
- R6: In full page, beat k is (start + k) mod 512, wrapping from 511 to 0. `last_o` never rises, and the burst runs until a stop or a load.
- R7: Full page with interleaved order selected behaves exactly as sequential full page.
- R8: A stop sampled without a load makes `col_vld_o` 0 from the next cycle. When load and stop are sampled together, the load wins.
- R9: A load during a burst restarts on the next cycle from the new start column with the new length and order.
- R10: The reserved length codes 3'b100, 3'b101 and 3'b110 give a one-column burst.
- R11: Length code, order and start column are sampled only with the load. Changes while a burst runs do not alter its columns or its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Start a new burst from `start_col_i` |
| start_col_i | input | 9 | First column of the burst |
| len_code_i | input | 3 | Burst length code |
| order_i | input | 1 | 0 sequential, 1 interleaved |
| stop_i | input | 1 | End the current burst |
| col_o | output | 9 | Current column |
| col_vld_o | output | 1 | `col_o` carries a burst column |
| last_o | output | 1 | Final column of a finite burst |

## Verification
Every start column from 0 to 511 is run with each finite length in both orders. This shows whether the wrap stays inside the aligned block and whether the XOR pattern differs from the sequential one for every alignment. While each of those bursts runs, the length and order inputs are scrambled, which separates sampling at load from sampling every cycle. Reserved codes and full page with either order are run from starts close to the top of the row, so the 511-to-0 wrap and the missing done pulse are visible. Separate sequences then issue stop alone, stop together with load, and a load in the middle of a burst, to show the priority and the restart timing.

// File: rtl/bcc_pkg.sv
// Shared constants for the burst column sequencer: length code values
// and the width of the length code field.
package bcc_pkg;
    localparam int LEN_W = 3;
    localparam logic [LEN_W-1:0] LEN_1    = 3'b000;
    localparam logic [LEN_W-1:0] LEN_2    = 3'b001;
    localparam logic [LEN_W-1:0] LEN_4    = 3'b010;
    localparam logic [LEN_W-1:0] LEN_8    = 3'b011;
    localparam logic [LEN_W-1:0] LEN_FULL = 3'b111;
endpackage

// File: rtl/bcc_cfg_decode.sv
// Turns a length code and order select into a low-bit mask, a full-page
// flag and the effective interleave flag. Assumes COL_W >= 3. Reserved
// codes decode as length one; full page forces sequential order.
module bcc_cfg_decode #(
    parameter int COL_W = 9
) (
    input  logic [bcc_pkg::LEN_W-1:0] len_code,
    input  logic                      order_xor,
    output logic [COL_W-1:0]          mask,
    output logic                      full,
    output logic                      xor_eff
);
    int span_log2;

    // Pick the number of wrapping low bits from the length code.
    always_comb begin
        full = (len_code == bcc_pkg::LEN_FULL);
        case (len_code)
            bcc_pkg::LEN_2: span_log2 = 1;
            bcc_pkg::LEN_4: span_log2 = 2;
            bcc_pkg::LEN_8: span_log2 = 3;
            default:        span_log2 = 0;
        endcase
    end

    // Build the mask of counting bits; all bits count in full page.
    always_comb begin
        for (int i = 0; i < COL_W; i++) begin
            mask[i] = full | (i < span_log2);
        end
    end

    assign xor_eff = order_xor & ~full;
endmodule

// File: rtl/bcc_beat_counter.sv
// Tracks whether a burst is running and which beat it is on. Captures
// the mask and full-page flag at load; load outranks stop.
module bcc_beat_counter #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             stop,
    input  logic [COL_W-1:0] mask_d,
    input  logic             full_d,
    output logic             active,
    output logic [COL_W-1:0] beat,
    output logic [COL_W-1:0] mask_q,
    output logic             last
);
    logic full_q;

    // Burst state: start on load, end on stop or final beat, else advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            beat   <= '0;
            mask_q <= '0;
            full_q <= 1'b0;
        end else if (load) begin
            active <= 1'b1;
            beat   <= '0;
            mask_q <= mask_d;
            full_q <= full_d;
        end else if (stop) begin
            active <= 1'b0;
        end else if (active) begin
            if (last) active <= 1'b0;
            else      beat   <= beat + 1'b1;
        end
    end

    assign last = active & ~full_q & (beat == mask_q);
endmodule

// File: rtl/bcc_addr_gen.sv
// Forms the column from the captured start, the beat index and the mask.
// Assumes the beat never exceeds the mask of a finite burst.
module bcc_addr_gen #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [COL_W-1:0] start_d,
    input  logic             xor_d,
    input  logic [COL_W-1:0] mask,
    input  logic [COL_W-1:0] beat,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] start_q;
    logic             xor_q;
    logic [COL_W-1:0] seq_col;

    // Capture start column and ordering with the load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            xor_q   <= 1'b0;
        end else if (load) begin
            start_q <= start_d;
            xor_q   <= xor_d;
        end
    end

    // Sequential: add in the low bits only, keep the block bits.
    assign seq_col = (start_q & ~mask) | ((start_q + beat) & mask);
    assign col     = xor_q ? (start_q ^ beat) : seq_col;
endmodule

// File: rtl/burst_col_counter.sv
// Top of the burst column sequencer. One column per clock after a load;
// stop and reload act on any cycle. All control is registered at load.
module burst_col_counter #(
    parameter int COL_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_i,
    input  logic [COL_W-1:0]          start_col_i,
    input  logic [bcc_pkg::LEN_W-1:0] len_code_i,
    input  logic                      order_i,
    input  logic                      stop_i,
    output logic [COL_W-1:0]          col_o,
    output logic                      col_vld_o,
    output logic                      last_o
);
    logic [COL_W-1:0] mask_d, mask_q, beat;
    logic             full_d, xor_d;

    bcc_cfg_decode #(.COL_W(COL_W)) dec_i (
        .len_code (len_code_i),
        .order_xor(order_i),
        .mask     (mask_d),
        .full     (full_d),
        .xor_eff  (xor_d)
    );

    bcc_beat_counter #(.COL_W(COL_W)) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_i),
        .stop  (stop_i),
        .mask_d(mask_d),
        .full_d(full_d),
        .active(col_vld_o),
        .beat  (beat),
        .mask_q(mask_q),
        .last  (last_o)
    );

    bcc_addr_gen #(.COL_W(COL_W)) gen_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load_i),
        .start_d(start_col_i),
        .xor_d  (xor_d),
        .mask   (mask_q),
        .beat   (beat),
        .col    (col_o)
    );
endmodule

// File: rtl/bcc_checker.sv
// Property checker for the burst column sequencer, bound to the top.
// Keeps its own copy of the full-page selection seen at load.
module bcc_checker #(
    parameter int COL_W = 9
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      load_i,
    input logic [COL_W-1:0]          start_col_i,
    input logic [bcc_pkg::LEN_W-1:0] len_code_i,
    input logic                      stop_i,
    input logic [COL_W-1:0]          col_o,
    input logic                      col_vld_o,
    input logic                      last_o
);
    logic fp_q;

    // Remember whether the running burst was requested as full page.
    always_ff @(posedge clk) begin
        if (!rst_n)      fp_q <= 1'b0;
        else if (load_i) fp_q <= (len_code_i == bcc_pkg::LEN_FULL);
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !col_vld_o && !last_o); // R1
    AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> col_vld_o && col_o == $past(start_col_i)); // R2
    AST_KEEP_GOING: assert property (@(posedge clk) disable iff (!rst_n)
        col_vld_o && !last_o && !stop_i |=> col_vld_o); // R2
    AST_DONE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> col_vld_o); // R3
    AST_DONE_END: assert property (@(posedge clk) disable iff (!rst_n)
        last_o && !load_i |=> !col_vld_o); // R3
    AST_FULL_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fp_q |-> !last_o); // R6
    AST_STOP_END: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i && !load_i |=> !col_vld_o); // R8
endmodule

bind burst_col_counter bcc_checker #(.COL_W(COL_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .start_col_i(start_col_i),
    .len_code_i (len_code_i),
    .stop_i     (stop_i),
    .col_o      (col_o),
    .col_vld_o  (col_vld_o),
    .last_o     (last_o)
);

// File: tb/burst_col_counter_tb_top.sv
// Sweeping bench for the burst column sequencer; expected columns are
// computed arithmetically from the requirement text.
module burst_col_counter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0;
    logic [8:0] start_col_i = '0;
    logic [2:0] len_code_i = '0;
    logic       order_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [8:0] col_o;
    logic       col_vld_o, last_o;
    int checks = 0;
    int errs = 0;

    always #5 clk = ~clk;

    burst_col_counter dut_i (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .order_i(order_i), .stop_i(stop_i),
        .col_o(col_o), .col_vld_o(col_vld_o), .last_o(last_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int bl_of(input int code);
        case (code)
            1: return 2;
            2: return 4;
            3: return 8;
            7: return 512;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col(input int s, input int code, input int ord, input int k);
        int bl = bl_of(code);
        if (bl == 512) return (s + k) % 512;
        if (ord == 1) return s ^ k;
        return (s & ~(bl - 1)) | ((s + k) & (bl - 1));
    endfunction

    // Apply a load; returns at the negedge where beat 0 is visible.
    task automatic start_burst(input int s, input int code, input int ord);
        @(negedge clk);
        start_col_i = 9'(s); len_code_i = 3'(code); order_i = ord[0]; load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    // Run a finite burst, scrambling config inputs after the load (R11).
    task automatic run_burst(input int s, input int code, input int ord, input string req);
        int bl = bl_of(code);
        start_burst(s, code, ord);
        len_code_i = 3'(~code); order_i = ~ord[0]; start_col_i = 9'(~s);
        for (int k = 0; k < bl; k++) begin
            chk(col_vld_o == 1'b1, {req, " R2 valid"}, int'(col_vld_o), 1);
            chk(int'(col_o) == exp_col(s, code, ord, k), {req, " R11 column"}, int'(col_o), exp_col(s, code, ord, k));
            chk(last_o == (k == bl - 1), {req, " R3 last"}, int'(last_o), int'(k == bl - 1));
            @(negedge clk);
        end
        chk(col_vld_o == 1'b0, {req, " R3 ends"}, int'(col_vld_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(col_vld_o == 1'b0 && last_o == 1'b0, "R1 in reset", int'(col_vld_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(col_vld_o == 1'b0 && last_o == 1'b0, "R1 after reset", int'(col_vld_o), 0);

        // Every start with each finite length, both orders (R3, R4, R5).
        for (int ord = 0; ord < 2; ord++)
            for (int code = 0; code < 4; code++)
                for (int s = 0; s < 512; s++)
                    run_burst(s, code, ord, ord ? "R5 xor" : "R4 seq");

        // Reserved codes act as length one (R10).
        for (int code = 4; code < 7; code++)
            for (int s = 0; s < 512; s += 37)
                run_burst(s, code, code & 1, "R10 reserved");

        // Full page, both orders, wraps and never finishes (R6, R7).
        for (int ord = 0; ord < 2; ord++) begin
            start_burst(505, 7, ord);
            for (int k = 0; k < 600; k++) begin
                chk(col_vld_o == 1'b1, "R6 full valid", int'(col_vld_o), 1);
                chk(int'(col_o) == (505 + k) % 512, ord ? "R7 full xor col" : "R6 full col",
                    int'(col_o), (505 + k) % 512);
                chk(last_o == 1'b0, "R6 no last", int'(last_o), 0);
                if (k == 599) stop_i = 1'b1;
                @(negedge clk);
            end
            stop_i = 1'b0;
            chk(col_vld_o == 1'b0, "R8 stop full", int'(col_vld_o), 0);
        end

        // Stop mid finite burst (R8).
        start_burst(16, 3, 0);
        @(negedge clk);
        chk(int'(col_o) == 17, "R8 before stop", int'(col_o), 17);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk(col_vld_o == 1'b0 && last_o == 1'b0, "R8 stopped", int'(col_vld_o), 0);
        @(negedge clk);
        chk(col_vld_o == 1'b0, "R8 stays idle", int'(col_vld_o), 0);

        // Load and stop together: load wins (R8).
        start_burst(200, 3, 0);
        start_col_i = 9'd100; len_code_i = 3'd2; order_i = 1'b0;
        load_i = 1'b1; stop_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0; stop_i = 1'b0;
        chk(col_vld_o == 1'b1 && int'(col_o) == 100, "R8 load beats stop", int'(col_o), 100);

        // Restart mid burst with new length and order (R9).
        start_burst(40, 3, 0);
        @(negedge clk);
        chk(int'(col_o) == 41, "R9 old beat", int'(col_o), 41);
        start_col_i = 9'd302; len_code_i = 3'd2; order_i = 1'b1; load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk(int'(col_o) == (302 ^ k), "R9 new column", int'(col_o), 302 ^ k);
            chk(last_o == (k == 3), "R9 new last", int'(last_o), int'(k == 3));
            @(negedge clk);
        end
        chk(col_vld_o == 1'b0, "R9 ends", int'(col_vld_o), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end
endmodule